// File: doc/BRIEF.md
# Program Counter Update Unit

This block holds the program counter of a multicycle processor and chooses the value it takes next. A controller supplies a 2-bit source select and two write strobes. The unconditional strobe handles sequential fetch, jumps and exception entry. The conditional strobe handles a taken branch, and it acts only when the zero flag of an ALU subtraction shows that the two branch operands are equal. The candidate values are the incremented PC computed by the ALU, the branch target held in the ALU output register, a jump target built from the current PC and the instruction word, and a fixed vector address for each exception cause.

The block also keeps the exception state. When the controller raises an exception, the block records the cause code. At the same time it saves the address of the faulting instruction, which is the current PC minus 4, because the PC was already advanced during fetch. The ALU, the memories and the register file are outside this block, and their results arrive on input ports.

Top module: `pc_update_unit`

## Requirements
- R1: While reset is asserted (rst_n low), and after it is released, pc_o, epc_o and cause_o read zero until the first write.
- R2: With pc_wr_en high and src_sel = 2'b00, pc_o equals alu_result one clock later.
- R3: With an effective write and src_sel = 2'b01, pc_o equals alu_out one clock later.
- R4: With an effective write and src_sel = 2'b10, the next pc_o is formed as follows: bits [31:28] come from the old pc_o, bits [27:2] come from jump_field[25:0], and bits [1:0] are zero.
- R5: With an effective write and src_sel = 2'b11, the next pc_o is 0xC0000000 when exc_cause is 0 (undefined instruction) and 0xC0000020 when exc_cause is 1 (arithmetic overflow).
- R6: When pc_wr_cond is high and pc_wr_en is low, the PC is written if alu_zero is 1 and holds its value if alu_zero is 0.
- R7: When neither strobe produces a write, pc_o keeps its value whatever src_sel and the data inputs carry.
- R8: When exc_raise is high, epc_o becomes the old pc_o minus 4 and cause_o becomes exc_cause one clock later. When exc_raise is low, both keep their values.
- R9: pc_wr_en writes the PC regardless of alu_zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_sel | input | 2 | Next-PC source: 00 incremented, 01 branch target, 10 jump, 11 vector |
| pc_wr_en | input | 1 | Unconditional PC write strobe |
| pc_wr_cond | input | 1 | Branch write strobe, qualified by alu_zero |
| alu_zero | input | 1 | Zero flag of the ALU subtraction |
| alu_result | input | 32 | Combinational ALU output (PC+4 during fetch) |
| alu_out | input | 32 | ALU output register (branch target) |
| jump_field | input | 26 | Target field of the jump instruction |
| exc_raise | input | 1 | Record exception state this cycle |
| exc_cause | input | 1 | Cause code: 0 undefined instruction, 1 overflow |
| pc_o | output | 32 | Current program counter |
| epc_o | output | 32 | Saved address of the faulting instruction |
| cause_o | output | 1 | Recorded cause code |

## Verification
The bench sweeps every combination of the four select codes, both strobes and the zero flag, across several data patterns, both exception cause values, and exc_raise low and high. The patterns separate the sources from each other, because the incremented value, the branch target and the jump field differ in each round. The zero flag combinations separate a conditional write from an unconditional one and from a hold. Letting the PC wander through high addresses shows whether the jump keeps the old upper nibble, and whether the saved exception address follows the PC minus 4 or only the latest write.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
    typedef enum logic [1:0] {
        SRC_SEQ    = 2'b00,
        SRC_BRANCH = 2'b01,
        SRC_JUMP   = 2'b10,
        SRC_VECTOR = 2'b11
    } pc_src_e;
endpackage

// File: rtl/pcu_next_sel.sv
module pcu_next_sel #(
    parameter int          ADDR_W   = 32,
    parameter int          JFIELD_W = 26,
    parameter logic [31:0] VEC_BASE = 32'hC000_0000,
    parameter logic [31:0] VEC_STEP = 32'h0000_0020
) (
    input  logic [1:0]          src,
    input  logic [ADDR_W-1:0]   pc_q,
    input  logic [ADDR_W-1:0]   seq_val,
    input  logic [ADDR_W-1:0]   branch_val,
    input  logic [JFIELD_W-1:0] jfield,
    input  logic                cause,
    output logic [ADDR_W-1:0]   next_pc
);
    import pcu_pkg::*;
    localparam int HI_W = ADDR_W - JFIELD_W - 2;

    logic [ADDR_W-1:0] jump_val;
    logic [ADDR_W-1:0] vec_val;

    always_comb begin
        jump_val = {pc_q[ADDR_W-1 -: HI_W], jfield, 2'b00};
        vec_val  = ADDR_W'(VEC_BASE) + (cause ? ADDR_W'(VEC_STEP) : '0);
        unique case (pc_src_e'(src))
            SRC_SEQ:    next_pc = seq_val;
            SRC_BRANCH: next_pc = branch_val;
            SRC_JUMP:   next_pc = jump_val;
            SRC_VECTOR: next_pc = vec_val;
            default:    next_pc = seq_val;
        endcase
    end
endmodule

// File: rtl/pcu_exc_capture.sv
module pcu_exc_capture #(
    parameter int ADDR_W      = 32,
    parameter int INSTR_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              raise,
    input  logic              cause_in,
    input  logic [ADDR_W-1:0] pc_q,
    output logic [ADDR_W-1:0] epc_q,
    output logic              cause_q
);
    typedef struct packed {
        logic [ADDR_W-1:0] epc;
        logic              cause;
    } exc_st_t;

    exc_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (raise) begin
            st_d.epc   = pc_q - ADDR_W'(INSTR_BYTES);
            st_d.cause = cause_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign epc_q   = st_q.epc;
    assign cause_q = st_q.cause;

    // R8
    epc_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        raise |=> (epc_q == $past(pc_q) - ADDR_W'(INSTR_BYTES)) && (cause_q == $past(cause_in)));
    // R8
    exc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !raise |=> $stable(epc_q) && $stable(cause_q));
endmodule

// File: rtl/pc_update_unit.sv
module pc_update_unit #(
    parameter int          ADDR_W   = 32,
    parameter int          JFIELD_W = 26,
    parameter logic [31:0] VEC_BASE = 32'hC000_0000,
    parameter logic [31:0] VEC_STEP = 32'h0000_0020
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          src_sel,
    input  logic                pc_wr_en,
    input  logic                pc_wr_cond,
    input  logic                alu_zero,
    input  logic [ADDR_W-1:0]   alu_result,
    input  logic [ADDR_W-1:0]   alu_out,
    input  logic [JFIELD_W-1:0] jump_field,
    input  logic                exc_raise,
    input  logic                exc_cause,
    output logic [ADDR_W-1:0]   pc_o,
    output logic [ADDR_W-1:0]   epc_o,
    output logic                cause_o
);
    localparam int HI_W = ADDR_W - JFIELD_W - 2;

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
    } pc_st_t;

    pc_st_t            st_d, st_q;
    logic [ADDR_W-1:0] next_pc;
    logic              wr_fire;

    pcu_next_sel #(
        .ADDR_W(ADDR_W), .JFIELD_W(JFIELD_W),
        .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
    ) sel_i (
        .src(src_sel), .pc_q(st_q.pc), .seq_val(alu_result),
        .branch_val(alu_out), .jfield(jump_field), .cause(exc_cause),
        .next_pc(next_pc)
    );

    pcu_exc_capture #(.ADDR_W(ADDR_W), .INSTR_BYTES(4)) exc_i (
        .clk(clk), .rst_n(rst_n), .raise(exc_raise), .cause_in(exc_cause),
        .pc_q(st_q.pc), .epc_q(epc_o), .cause_q(cause_o)
    );

    always_comb begin
        wr_fire = pc_wr_en | (pc_wr_cond & alu_zero);
        st_d    = st_q;
        if (wr_fire) st_d.pc = next_pc;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pc_o = st_q.pc;

    // R7
    pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pc_wr_en && !(pc_wr_cond && alu_zero)) |=> $stable(pc_o));
    // R2
    seq_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_wr_en && src_sel == 2'b00) |=> pc_o == $past(alu_result));
    // R4
    jump_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_wr_en && src_sel == 2'b10) |=>
        (pc_o[1:0] == 2'b00) && (pc_o[ADDR_W-1 -: HI_W] == $past(pc_o[ADDR_W-1 -: HI_W])));
    // R5
    vector_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_wr_en && src_sel == 2'b11 && !exc_cause) |=> pc_o == ADDR_W'(VEC_BASE));
    // R6
    cond_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_wr_cond && !pc_wr_en && !alu_zero) |=> $stable(pc_o));
endmodule

// File: tb/pc_update_unit_tb_top.sv
module pc_update_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  src_sel = '0;
    logic        pc_wr_en = 1'b0, pc_wr_cond = 1'b0, alu_zero = 1'b0;
    logic [31:0] alu_result = '0, alu_out = '0;
    logic [25:0] jump_field = '0;
    logic        exc_raise = 1'b0, exc_cause = 1'b0;
    logic [31:0] pc_o, epc_o;
    logic        cause_o;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    pc_update_unit dut_i (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .pc_wr_en(pc_wr_en),
        .pc_wr_cond(pc_wr_cond), .alu_zero(alu_zero), .alu_result(alu_result),
        .alu_out(alu_out), .jump_field(jump_field), .exc_raise(exc_raise),
        .exc_cause(exc_cause), .pc_o(pc_o), .epc_o(epc_o), .cause_o(cause_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        #4000000;
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] exp_pc, exp_epc, nxt;
        logic        exp_cause, wr;
        string       req;
        // R1: outputs zero during and after reset
        repeat (3) @(posedge clk);
        #1;
        check("R1 pc in reset", pc_o, 32'h0);
        check("R1 epc in reset", epc_o, 32'h0);
        check("R1 cause in reset", {31'b0, cause_o}, 32'h0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 pc after reset", pc_o, 32'h0);
        exp_pc = 32'h0; exp_epc = 32'h0; exp_cause = 1'b0;

        for (int pat = 0; pat < 8; pat++) begin
            for (int combo = 0; combo < 64; combo++) begin
                src_sel    = combo[1:0];
                pc_wr_en   = combo[2];
                pc_wr_cond = combo[3];
                alu_zero   = combo[4];
                exc_cause  = combo[5];
                exc_raise  = combo[0] ^ combo[3] ^ pat[0];
                alu_result = exp_pc + 32'd4 + 32'h1357_0000 * pat;
                alu_out    = 32'h9E37_79B9 * (pat + 1) ^ (32'h0000_1000 * combo);
                jump_field = 26'(32'h02A5_5A5A ^ (32'h0011_1111 * pat) ^ combo);
                wr = pc_wr_en | (pc_wr_cond & alu_zero);
                case (src_sel)
                    2'b00: begin nxt = alu_result; req = "R2"; end
                    2'b01: begin nxt = alu_out; req = "R3"; end
                    2'b10: begin nxt = {exp_pc[31:28], jump_field, 2'b00}; req = "R4"; end
                    default: begin nxt = exc_cause ? 32'hC000_0020 : 32'hC000_0000; req = "R5"; end
                endcase
                if (!pc_wr_en && pc_wr_cond) req = {req, "/R6"};
                else if (!wr) req = "R7";
                else if (pc_wr_en && !alu_zero) req = {req, "/R9"};
                if (exc_raise) begin
                    exp_epc   = exp_pc - 32'd4;
                    exp_cause = exc_cause;
                end
                if (wr) exp_pc = nxt;
                @(posedge clk); #1;
                check({req, " pc"}, pc_o, exp_pc);
                check("R8 epc", epc_o, exp_epc);
                check("R8 cause", {31'b0, cause_o}, {31'b0, exp_cause});
            end
        end
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule